// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block walks a ring of transmit descriptors kept in a memory it shares with the host. Each descriptor is 16 bytes, made of four 32-bit words: a control word, a tag word that the engine does not use, and the low and high halves of a buffer address. Software loads a ring base address and then writes a poll byte to ring the doorbell. The engine reads the control word at its current ring position. If the host has handed that descriptor to hardware, the engine reads the buffer address. It then presents the address and the frame length as a job and waits for the job to be reported done. After that it writes the control word back with ownership returned to the host, and pulses a transmit-complete interrupt bit.

The engine keeps going until it finds a control word that the host still owns. A flag in the descriptor itself, and not a configured ring size, marks the last slot; after that slot the next fetch starts again at the base. A doorbell that arrives while the engine is working is held. When the engine would otherwise stop, it makes one more scan at the position where it stopped.

Top module: `txr_engine`

## Requirements
- R1: After reset the engine is idle: `job_valid`, `mem_req` and `mem_we` are low and `int_status` is all zeros.
- R2: A write of `poll_wdata` with bit 6 set starts a scan from the current ring index. A poll write with bit 6 clear has no effect, whether the engine is idle or busy.
- R3: Descriptor i lives at byte address base + 16*i. The control word is at offset 0, the low buffer address at offset 8 and the high half at offset 12. `job_addr` is {high, low}.
- R4: `job_len` equals control bits [15:0] of the descriptor being served, and this holds for every value including 0 and 0xFFFF.
- R5: A control word whose bit 31 (ownership) is clear ends the scan, and that descriptor is neither served nor written.
- R6: `job_valid`, `job_addr` and `job_len` stay high and unchanged until a cycle in which `job_done` is high.
- R7: After `job_done`, the control word is written back to its own address with bit 31 cleared and bits [30:0] unchanged, including end-of-ring bit 30.
- R8: `int_status` bit 2 pulses high for exactly one cycle, in the cycle after each control write-back. All other bits of `int_status` stay 0.
- R9: After a descriptor whose control bit 30 (end of ring) is set, the next descriptor fetched is the one at the base address.
- R10: Writing the base register resets the ring index to 0.
- R11: A doorbell that arrives while the engine is busy is latched. When the engine next finds a host-owned descriptor, it reads that control word once more before going idle.
- R12: A scan begins at the index where the previous scan stopped, not at the base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_we | input | 1 | Load the ring base address |
| base_wdata | input | AW | Ring base byte address, 16-byte aligned |
| poll_we | input | 1 | Poll byte write strobe |
| poll_wdata | input | 8 | Poll byte; bit 6 is the normal-queue doorbell |
| mem_req | output | 1 | Descriptor memory access |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Byte address of the 32-bit word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| job_valid | output | 1 | A buffer job is presented |
| job_addr | output | 64 | Buffer address of the job |
| job_len | output | 16 | Frame length of the job |
| job_done | input | 1 | Job finished |
| int_status | output | 16 | Interrupt event pulses; bit 2 is transmit complete |

## Verification
The bench checks the ring wrap in two ways. It places an owned descriptor just past the end-of-ring slot; a design that wrapped on a count, or not at all, would serve that descriptor. It then reloads the base in the middle of the ring; a design that kept its old index would serve the frames in the wrong order. Control words with the end-of-ring flag are compared word for word after write-back, which catches a write-back that drops bit 30. The bench counts reads of the stop slot to check the held doorbell: a design that ignored a busy-time doorbell would read that slot once instead of twice, and one that latched a poll write without bit 6 would read it twice. The lengths 0 and 0xFFFF, and a poll write with only bit 6 clear, cover the edge values.

// File: rtl/txr_pkg.sv
package txr_pkg;
  localparam int DW             = 32;
  localparam int DESC_BYTES     = 16;
  localparam int CTRL_OWN_BIT   = 31;
  localparam int CTRL_EOR_BIT   = 30;
  localparam int CTRL_LEN_W     = 16;
  localparam int POLL_NORMAL_BIT = 6;
  localparam int IRQ_TXOK_BIT   = 2;
  localparam int IRQ_W          = 16;

  localparam logic [1:0] WSEL_CTRL = 2'd0;
  localparam logic [1:0] WSEL_LO   = 2'd2;
  localparam logic [1:0] WSEL_HI   = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_CTRL, ST_CHK_CTRL, ST_RD_LO, ST_RD_HI, ST_GOT_HI, ST_JOB, ST_WB
  } txr_state_e;

  // byte offset of one word of one descriptor from the ring base
  function automatic logic [31:0] desc_offset(input logic [31:0] idx, input logic [1:0] wsel);
    return idx * 32'(DESC_BYTES) + 32'(wsel) * 32'd4;
  endfunction

  // control word as returned to the host
  function automatic logic [DW-1:0] hand_back(input logic [DW-1:0] ctrl);
    logic [DW-1:0] r;
    r = ctrl;
    r[CTRL_OWN_BIT] = 1'b0;
    return r;
  endfunction
endpackage

// File: rtl/txr_ptr.sv
module txr_ptr import txr_pkg::*; #(
  parameter int AW = 16,
  parameter int IW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          base_we,
  input  logic [AW-1:0] base_wdata,
  input  logic          adv,
  input  logic          wrap,
  input  logic [1:0]    wsel,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] base_q;
  logic [IW-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      idx_q  <= '0;
    end else if (base_we) begin
      base_q <= base_wdata;
      idx_q  <= '0;
    end else if (adv) begin
      idx_q <= wrap ? '0 : idx_q + IW'(1);
    end
  end

  assign addr = base_q + AW'(desc_offset(32'(idx_q), wsel));

  // R9: after an end-of-ring slot the next control fetch is at the base
  a_r9_wrap_to_base: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && wrap && !base_we) |=> (addr == base_q));
  // R10: a base write restarts the ring at slot 0
  a_r10_base_resets_index: assert property (@(posedge clk) disable iff (!rst_n)
    base_we |=> (idx_q == '0));
endmodule

// File: rtl/txr_doorbell.sv
module txr_doorbell import txr_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       poll_we,
  input  logic [7:0] poll_wdata,
  input  logic       engine_idle,
  input  logic       take_pending,
  output logic       go,
  output logic       pending_q
);
  logic ring;
  logic unused_poll_bits;

  assign ring = poll_we && poll_wdata[POLL_NORMAL_BIT];
  assign unused_poll_bits = ^(poll_wdata & ~(8'h1 << POLL_NORMAL_BIT));
  assign go = ring || pending_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                     pending_q <= 1'b0;
    else if (ring && !engine_idle)  pending_q <= 1'b1;
    else if (take_pending)          pending_q <= 1'b0;
  end

  // R11: a busy-time doorbell is never lost
  a_r11_latch_busy_ring: assert property (@(posedge clk) disable iff (!rst_n)
    (ring && !engine_idle) |=> pending_q);
  // R2: a poll write without the doorbell bit never arms the latch
  a_r2_no_bit_no_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending_q && !(poll_we && poll_wdata[POLL_NORMAL_BIT])) |=> !pending_q);
endmodule

// File: rtl/txr_fsm.sv
module txr_fsm import txr_pkg::*; (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                go,
  input  logic                pending_q,
  input  logic [DW-1:0]       mem_rdata,
  input  logic                job_done,
  output logic                mem_req,
  output logic                mem_we,
  output logic [DW-1:0]       mem_wdata,
  output logic [1:0]          wsel,
  output logic                job_valid,
  output logic [2*DW-1:0]     job_addr,
  output logic [CTRL_LEN_W-1:0] job_len,
  output logic                adv,
  output logic                wrap,
  output logic                engine_idle,
  output logic                take_pending,
  output logic                txok
);
  txr_state_e st;
  logic [DW-1:0] ctrl_q, lo_q, hi_q;
  logic          own_seen;

  assign own_seen = mem_rdata[CTRL_OWN_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      ctrl_q <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      txok   <= 1'b0;
    end else begin
      txok <= (st == ST_WB);
      case (st)
        ST_IDLE:     if (go) st <= ST_RD_CTRL;
        ST_RD_CTRL:  st <= ST_CHK_CTRL;
        ST_CHK_CTRL: begin
          ctrl_q <= mem_rdata;
          if (own_seen)       st <= ST_RD_LO;
          else if (pending_q) st <= ST_RD_CTRL;
          else                st <= ST_IDLE;
        end
        ST_RD_LO:    st <= ST_RD_HI;
        ST_RD_HI:    begin lo_q <= mem_rdata; st <= ST_GOT_HI; end
        ST_GOT_HI:   begin hi_q <= mem_rdata; st <= ST_JOB; end
        ST_JOB:      if (job_done) st <= ST_WB;
        ST_WB:       st <= ST_RD_CTRL;
        default:     st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req = 1'b0;
    wsel    = WSEL_CTRL;
    case (st)
      ST_RD_CTRL: mem_req = 1'b1;
      ST_RD_LO:   begin mem_req = 1'b1; wsel = WSEL_LO; end
      ST_RD_HI:   begin mem_req = 1'b1; wsel = WSEL_HI; end
      ST_WB:      mem_req = 1'b1;
      default:    ;
    endcase
  end

  assign mem_we       = (st == ST_WB);
  assign mem_wdata    = hand_back(ctrl_q);
  assign job_valid    = (st == ST_JOB);
  assign job_addr     = {hi_q, lo_q};
  assign job_len      = ctrl_q[CTRL_LEN_W-1:0];
  assign adv          = (st == ST_WB);
  assign wrap         = ctrl_q[CTRL_EOR_BIT];
  assign engine_idle  = (st == ST_IDLE);
  assign take_pending = pending_q &&
                        ((st == ST_IDLE) || (st == ST_CHK_CTRL && !own_seen));

  // R6: a presented job does not move until it is done
  a_r6_job_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (job_valid && !job_done) |=> (job_valid && $stable(job_addr) && $stable(job_len)));
  // R7: a write-back never hands the slot to hardware again
  a_r7_wb_releases: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !mem_wdata[CTRL_OWN_BIT]);
  // R5: a host-owned slot with nothing latched leads to idle, nothing served
  a_r5_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CHK_CTRL && !own_seen && !pending_q) |=> (!mem_req && !job_valid));
  // R8: the completion event follows a write-back and lasts one cycle
  a_r8_txok_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    txok |=> !txok);
  a_r8_txok_after_wb: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> txok);
endmodule

// File: rtl/txr_engine.sv
module txr_engine import txr_pkg::*; #(
  parameter int AW = 16,
  parameter int IW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          base_we,
  input  logic [AW-1:0] base_wdata,
  input  logic          poll_we,
  input  logic [7:0]    poll_wdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic          job_valid,
  output logic [63:0]   job_addr,
  output logic [15:0]   job_len,
  input  logic          job_done,
  output logic [15:0]   int_status
);
  localparam int JAW = 2 * DW;

  logic       go, pending_q, take_pending, engine_idle;
  logic       adv, wrap, txok;
  logic [1:0] wsel;
  logic [JAW-1:0] job_addr_w;
  logic [CTRL_LEN_W-1:0] job_len_w;

  txr_doorbell u_bell (
    .clk, .rst_n, .poll_we, .poll_wdata, .engine_idle, .take_pending,
    .go, .pending_q
  );

  txr_ptr #(.AW(AW), .IW(IW)) u_ptr (
    .clk, .rst_n, .base_we, .base_wdata, .adv, .wrap, .wsel, .addr(mem_addr)
  );

  txr_fsm u_fsm (
    .clk, .rst_n, .go, .pending_q, .mem_rdata, .job_done,
    .mem_req, .mem_we, .mem_wdata, .wsel, .job_valid,
    .job_addr(job_addr_w), .job_len(job_len_w),
    .adv, .wrap, .engine_idle, .take_pending, .txok
  );

  assign job_addr = job_addr_w;
  assign job_len  = job_len_w;

  always_comb begin
    int_status = '0;
    int_status[IRQ_TXOK_BIT] = txok;
  end

  // R1: nothing moves while reset is held
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!mem_req && !job_valid && int_status == '0));
  // R3: reads fall on whole words of the descriptor
  a_r3_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00));
endmodule

// File: tb/txr_engine_tb.sv
module txr_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_we = 1'b0;
  logic [15:0] base_wdata = '0;
  logic        poll_we = 1'b0;
  logic [7:0]  poll_wdata = '0;
  logic        mem_req, mem_we;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        job_valid;
  logic [63:0] job_addr;
  logic [15:0] job_len;
  logic        job_done = 1'b0;
  logic [15:0] int_status;

  int n_checks = 0, n_fail = 0;
  logic [31:0] mem [0:1023];
  int rd_cnt [0:1023];
  logic [63:0] jlog_addr [0:63];
  logic [15:0] jlog_len  [0:63];
  int n_jobs = 0, n_irq = 0, job_wait = 0, job_dly = 0;
  logic we_prev = 1'b0;

  localparam logic [31:0] OWN = 32'h8000_0000;
  localparam logic [31:0] EOR = 32'h4000_0000;
  localparam logic [31:0] FSLS = 32'h3000_0000;

  always #4 clk = ~clk;

  txr_engine dut_i (
    .clk, .rst_n, .base_we, .base_wdata, .poll_we, .poll_wdata,
    .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_rdata,
    .job_valid, .job_addr, .job_len, .job_done, .int_status
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model: one-cycle read latency
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
      else begin
        mem_rdata <= mem[mem_addr[11:2]];
        rd_cnt[mem_addr[11:2]] <= rd_cnt[mem_addr[11:2]] + 1;
      end
    end
  end

  // job responder and interrupt monitor
  always @(negedge clk) begin
    if (job_valid) begin
      if (job_wait >= job_dly && !job_done) begin
        jlog_addr[n_jobs[5:0]] = job_addr;
        jlog_len[n_jobs[5:0]]  = job_len;
        n_jobs = n_jobs + 1;
        job_done = 1'b1;
      end else begin
        job_wait = job_wait + 1;
        job_done = 1'b0;
      end
    end else begin
      job_done = 1'b0;
      job_wait = 0;
    end
    if (int_status[2]) n_irq = n_irq + 1;
    if (we_prev || int_status != 16'h0) begin
      chk("R8 irq pulse after write-back", {48'h0, int_status}, we_prev ? 64'h4 : 64'h0);
    end
    we_prev = mem_we;
  end

  task automatic set_desc(input int base, input int idx, input logic [31:0] ctrl,
                          input logic [31:0] lo, input logic [31:0] hi);
    int w;
    w = (base + idx * 16) >> 2;
    mem[w] = ctrl; mem[w+1] = 32'h0; mem[w+2] = lo; mem[w+3] = hi;
  endtask

  function automatic logic [31:0] ctrl_at(input int base, input int idx);
    return mem[(base + idx * 16) >> 2];
  endfunction

  task automatic write_base(input logic [15:0] b);
    @(negedge clk); base_we = 1'b1; base_wdata = b;
    @(negedge clk); base_we = 1'b0;
  endtask

  task automatic poll(input logic [7:0] v);
    @(negedge clk); poll_we = 1'b1; poll_wdata = v;
    @(negedge clk); poll_we = 1'b0; poll_wdata = 8'h0;
  endtask

  task automatic wait_quiet();
    int q;
    q = 0;
    while (q < 12) begin
      @(negedge clk);
      if (!mem_req && !job_valid && !poll_we) q++; else q = 0;
    end
  endtask

  task automatic t_reset();
    chk("R1 job_valid", {63'h0, job_valid}, 64'h0);
    chk("R1 mem_req", {63'h0, mem_req}, 64'h0);
    chk("R1 int_status", {48'h0, int_status}, 64'h0);
  endtask

  task automatic t_basic();
    int j0, i0;
    write_base(16'h0100);
    set_desc(32'h100, 0, OWN | FSLS | 32'h0040, 32'h1000_0000, 32'h1);
    set_desc(32'h100, 1, OWN | FSLS | 32'hFFFF, 32'hDEAD_BEE0, 32'h2);
    set_desc(32'h100, 2, OWN | 32'h0000,        32'h3,         32'h0);
    set_desc(32'h100, 3, 32'h0000_1234,         32'h55,        32'h0);
    j0 = n_jobs; i0 = n_irq;
    poll(8'h40);
    wait_quiet();
    chk("R5 served up to first host-owned slot", 64'(n_jobs - j0), 64'd3);
    chk("R3 job addr 0", jlog_addr[j0], 64'h1_1000_0000);
    chk("R3 job addr 1", jlog_addr[j0+1], 64'h2_DEAD_BEE0);
    chk("R3 job addr 2", jlog_addr[j0+2], 64'h3);
    chk("R4 len 0x40", 64'(jlog_len[j0]), 64'h40);
    chk("R4 len max", 64'(jlog_len[j0+1]), 64'hFFFF);
    chk("R4 len zero", 64'(jlog_len[j0+2]), 64'h0);
    chk("R7 wb slot 0", 64'(ctrl_at(32'h100, 0)), 64'(FSLS | 32'h0040));
    chk("R7 wb slot 1", 64'(ctrl_at(32'h100, 1)), 64'(FSLS | 32'hFFFF));
    chk("R5 stop slot untouched", 64'(ctrl_at(32'h100, 3)), 64'h1234);
    chk("R8 irq count", 64'(n_irq - i0), 64'd3);
  endtask

  task automatic t_poll_bits();
    int j0;
    set_desc(32'h100, 3, OWN | 32'h0010, 32'h40, 32'h0);
    j0 = n_jobs;
    poll(8'hBF);
    wait_quiet();
    chk("R2 poll without bit 6 ignored", 64'(n_jobs - j0), 64'd0);
    chk("R2 slot still owned", 64'(ctrl_at(32'h100, 3)), 64'(OWN | 32'h0010));
    poll(8'h40);
    wait_quiet();
    chk("R12 resumes at stop index", 64'(n_jobs - j0), 64'd1);
    chk("R12 served slot 3", 64'(jlog_len[j0]), 64'h10);
  endtask

  task automatic t_wrap();
    int j0;
    write_base(16'h0400);
    set_desc(32'h400, 0, OWN | 32'h1, 32'hA0, 32'h0);
    set_desc(32'h400, 1, OWN | EOR | 32'h2, 32'hA1, 32'h0);
    set_desc(32'h400, 2, OWN | 32'h3, 32'hA2, 32'h0);
    j0 = n_jobs;
    poll(8'h40);
    wait_quiet();
    chk("R9 stop at wrap", 64'(n_jobs - j0), 64'd2);
    chk("R9 slot past end not served", 64'(ctrl_at(32'h400, 2)), 64'(OWN | 32'h3));
    chk("R7 end-of-ring kept", 64'(ctrl_at(32'h400, 1)), 64'(EOR | 32'h2));
    set_desc(32'h400, 0, OWN | 32'h5, 32'hB0, 32'h0);
    j0 = n_jobs;
    poll(8'h40);
    wait_quiet();
    chk("R9 next scan at base", 64'(n_jobs - j0), 64'd1);
    chk("R9 base slot served", jlog_addr[j0], 64'hB0);
    // index now 1; base reload must restart at slot 0
    write_base(16'h0400);
    set_desc(32'h400, 0, OWN | 32'h7, 32'hC0, 32'h0);
    set_desc(32'h400, 1, OWN | EOR | 32'h8, 32'hC1, 32'h0);
    j0 = n_jobs;
    poll(8'h40);
    wait_quiet();
    chk("R10 count", 64'(n_jobs - j0), 64'd2);
    chk("R10 first after reload is slot 0", 64'(jlog_len[j0]), 64'h7);
    chk("R10 second is slot 1", 64'(jlog_len[j0+1]), 64'h8);
  endtask

  task automatic t_busy_bell();
    int j0, r0, r1;
    logic [63:0] a0;
    write_base(16'h0800);
    set_desc(32'h800, 0, OWN | 32'h21, 32'hD0, 32'h0);
    set_desc(32'h800, 1, 32'h0, 32'h0, 32'h0);
    job_dly = 15;
    j0 = n_jobs; r0 = rd_cnt[(32'h810) >> 2];
    poll(8'h40);
    while (!job_valid) @(negedge clk);
    a0 = job_addr;
    poll(8'h40);
    repeat (6) @(negedge clk);
    chk("R6 job held", {63'h0, job_valid}, 64'h1);
    chk("R6 job addr stable", job_addr, a0);
    wait_quiet();
    chk("R11 one job", 64'(n_jobs - j0), 64'd1);
    chk("R11 stop slot rescanned", 64'(rd_cnt[(32'h810) >> 2] - r0), 64'd2);
    set_desc(32'h800, 1, OWN | 32'h22, 32'hD1, 32'h0);
    r1 = rd_cnt[(32'h820) >> 2];
    poll(8'h40);
    while (!job_valid) @(negedge clk);
    poll(8'h3F);
    wait_quiet();
    chk("R2 busy poll without bit 6 not latched", 64'(rd_cnt[(32'h820) >> 2] - r1), 64'd1);
    job_dly = 0;
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) begin mem[i] = '0; rd_cnt[i] = 0; end
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_poll_bits();
    t_wrap();
    t_busy_bell();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule